// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the host-facing control register set of an audio codec. A host reaches it through four byte-wide direct ports chosen by a 2-bit address: index, indexed data, status, and a programmed-I/O data port. The index port selects one of 32 indirect 8-bit registers. The data port then reads or writes the selected register. Each indirect register has its own write rule. Some are read-only. Some take only certain bits. The format register takes writes only while the mode-change enable bit of the index register is set, or, when that bit is clear, through a partial write path.

The datapaths that raise interrupts are outside this block. They report events on a 3-bit flag input. Each event sets the interrupt flag and one bit in the flag register. The host clears these flags by writing the status port or by lowering the playback flag bit in the flag register. The block drives the format register, the interface configuration register, the interrupt level and a one-cycle interrupt-clear pulse to the neighbouring logic. Reads are combinational. Writes and read side effects take effect on the rising clock edge while the matching enable is high.

Top module: `codec_index_regs`

## Requirements
- R1: After reset, the index port reads 0x40 and the indirect registers read as follows: 0x88 in registers 2 to 5, 18 and 19; 0x80 in registers 6 and 7; 0x08 in register 9; 0x8A in register 12; 0xA0 in registers 25 and 26; 0 in all others. At reset, irqOut and intClrPulse are 0.
- R2: Bit 7 of a value written to the index port is discarded, so the index port always reads bit 7 as 0. The other seven bits read back as written. Bit 6 is the mode-change enable (MCE).
- R3: The indirect register is selected by index bits 3:0 while bit 6 of register 12 is 0, and by index bits 4:0 while that bit is 1.
- R4: A data write to register 12 changes only its bit 6. Its other bits keep their values.
- R5: A data write to register 8 stores the full byte when MCE is 1. When MCE is 0 and register 24 bit 4 is 1, the write stores only bits 7:4 and keeps bits 3:0. Otherwise the write is dropped. Register 8 is always visible on fmtReg.
- R6: A data write to register 9 always leaves bit 5 at 0. Register 9 is always visible on ifCfgReg.
- R7: Register 11 is read-only. Writing the index port with bit 6 set, while MCE was 0 and register 9 bits 4:3 are not both 0, loads a calibration counter with CAL_LOAD. Each data-port read of register 11 while the counter is nonzero returns bit 5 set and decrements the counter.
- R8: Any write to the status port clears the interrupt flag (status bit 0, irqOut) and bits 6:4 of register 24. intClrPulse is high for exactly the cycle after the write.
- R9: A data write to register 24 that changes bit 4 from 1 to 0 clears the interrupt flag and raises intClrPulse for one cycle.
- R10: Data writes to the reserved registers 22, 27 and 29 are ignored.
- R11: Writes to the programmed-I/O port (address 3) are ignored, and that port reads 0.
- R12: Reads of the index, status and ordinary indirect registers have no side effects. The status port reads {7'b0, interrupt flag}.
- R13: flagSet bit n (n = 0..2) sets register 24 bit 4+n and the interrupt flag. A set takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Direct port select: 0 index, 1 data, 2 status, 3 programmed-I/O |
| wrEn | input | 1 | Write strobe for the direct port on addr |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Read strobe (enables read side effects) |
| rdData | output | 8 | Combinational read byte of the direct port on addr |
| flagSet | input | 3 | Event flags from the datapaths: playback, capture, timer |
| fmtReg | output | 8 | Current contents of register 8 |
| ifCfgReg | output | 8 | Current contents of register 9 |
| irqOut | output | 1 | Interrupt flag level |
| intClrPulse | output | 1 | One-cycle pulse after the interrupt flag is cleared by the host |

## Verification
The hardest case to reach is the partial format write. It needs MCE at 0, a playback event already recorded in register 24, and a format value written earlier under MCE, so that the kept low nibble can be told apart from the new one. The bench first stores 0x7E under MCE. It then clears MCE, raises flagSet[0], and writes 0x35, which must become 0x3E. The calibration bit is reached in the same way. Register 9 bits 4:3 are set first, then MCE gets a fresh 0-to-1 transition, and two reads of register 11 must see bit 5 once and then no more.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int NREG = 32;
  localparam int DW = 8;
  localparam int IW = $clog2(NREG);

  localparam logic [1:0] PORT_INDEX = 2'd0;
  localparam logic [1:0] PORT_DATA = 2'd1;
  localparam logic [1:0] PORT_STATUS = 2'd2;
  localparam logic [1:0] PORT_PIO = 2'd3;

  localparam logic [IW-1:0] REG_FORMAT = 5'd8;
  localparam logic [IW-1:0] REG_IFCFG = 5'd9;
  localparam logic [IW-1:0] REG_CALSTAT = 5'd11;
  localparam logic [IW-1:0] REG_MODE = 5'd12;
  localparam logic [IW-1:0] REG_RSV_A = 5'd22;
  localparam logic [IW-1:0] REG_FLAGS = 5'd24;
  localparam logic [IW-1:0] REG_RSV_B = 5'd27;
  localparam logic [IW-1:0] REG_RSV_C = 5'd29;

  localparam int MCE_BIT = 6;
  localparam int WIDE_BIT = 6;
  localparam int PLAY_FLAG_BIT = 4;
  localparam int CAL_BIT = 5;

  typedef struct packed {
    logic wrIdx;
    logic wrReg;
    logic [IW-1:0] wrSel;
    logic [DW-1:0] wrMask;
    logic clrStatus;
    logic clrInt;
    logic calLoad;
    logic calDec;
  } strobe_t;

  function automatic logic [DW-1:0] resetVal(input int i);
    case (i)
      2, 3, 4, 5, 18, 19: resetVal = 8'h88;
      6, 7: resetVal = 8'h80;
      9: resetVal = 8'h08;
      12: resetVal = 8'h8A;
      25, 26: resetVal = 8'hA0;
      default: resetVal = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/codec_regs_ctrl.sv
module codec_regs_ctrl
  import codec_regs_pkg::*;
#(
  parameter int CAL_W = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] addr,
  input  logic wrEn,
  input  logic [DW-1:0] wrData,
  input  logic rdEn,
  input  logic [6:0] idxReg,
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic intFlag,
  input  logic [CAL_W-1:0] calCnt,
  output strobe_t st,
  output logic [DW-1:0] rdData
);
  logic wideMode;
  logic mce;
  logic [IW-1:0] curIdx;
  logic calBusy;

  assign wideMode = regs[REG_MODE][WIDE_BIT];
  assign mce = idxReg[MCE_BIT];
  assign curIdx = wideMode ? idxReg[IW-1:0] : {1'b0, idxReg[IW-2:0]};
  assign calBusy = (calCnt != '0);

  always_comb begin
    st = '0;
    st.wrSel = curIdx;
    if (wrEn) begin
      case (addr)
        PORT_INDEX: begin
          st.wrIdx = 1'b1;
          st.calLoad = !mce && wrData[MCE_BIT] && (regs[REG_IFCFG][4:3] != 2'b00);
        end
        PORT_DATA: begin
          case (curIdx)
            REG_FORMAT: begin
              if (mce) begin
                st.wrReg = 1'b1;
                st.wrMask = 8'hFF;
              end else if (regs[REG_FLAGS][PLAY_FLAG_BIT]) begin
                st.wrReg = 1'b1;
                st.wrMask = 8'hF0;
              end
            end
            REG_IFCFG: begin
              st.wrReg = 1'b1;
              st.wrMask = 8'hDF;
            end
            REG_CALSTAT, REG_RSV_A, REG_RSV_B, REG_RSV_C: st.wrReg = 1'b0;
            REG_MODE: begin
              st.wrReg = 1'b1;
              st.wrMask = 8'h40;
            end
            REG_FLAGS: begin
              st.wrReg = 1'b1;
              st.wrMask = 8'hFF;
              st.clrInt = regs[REG_FLAGS][PLAY_FLAG_BIT] && !wrData[PLAY_FLAG_BIT];
            end
            default: begin
              st.wrReg = 1'b1;
              st.wrMask = 8'hFF;
            end
          endcase
        end
        PORT_STATUS: st.clrStatus = 1'b1;
        default: ;
      endcase
    end
    if (rdEn && addr == PORT_DATA && curIdx == REG_CALSTAT && calBusy) st.calDec = 1'b1;
  end

  always_comb begin
    case (addr)
      PORT_INDEX: rdData = {1'b0, idxReg};
      PORT_DATA: begin
        rdData = regs[curIdx];
        if (curIdx == REG_CALSTAT && calBusy) rdData[CAL_BIT] = 1'b1;
      end
      PORT_STATUS: rdData = {7'b0, intFlag};
      default: rdData = '0;
    endcase
  end

  // R5: a format write with neither enable path open produces no register write
  p_fmt_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == PORT_DATA && curIdx == REG_FORMAT && !mce && !regs[REG_FLAGS][PLAY_FLAG_BIT])
    |-> !st.wrReg);

  // R7: the counter is never decremented below zero
  p_cal_dec_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.calDec |-> calBusy);
endmodule

// File: rtl/codec_regs_dp.sv
module codec_regs_dp
  import codec_regs_pkg::*;
#(
  parameter int CAL_LOAD = 1,
  parameter int CAL_W = 1
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t st,
  input  logic [DW-1:0] wrData,
  input  logic [2:0] flagSet,
  output logic [6:0] idxReg,
  output logic [NREG-1:0][DW-1:0] regs,
  output logic intFlag,
  output logic [CAL_W-1:0] calCnt,
  output logic intClrPulse
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxReg <= 7'h40;
    else if (st.wrIdx) idxReg <= wrData[6:0];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] nxt;
    always_comb begin
      nxt = regs[i];
      if (st.wrReg && st.wrSel == IW'(i)) nxt = (regs[i] & ~st.wrMask) | (wrData & st.wrMask);
      if (i == int'(REG_FLAGS)) begin
        if (st.clrStatus) nxt[6:4] = 3'b000;
        nxt[6:4] = nxt[6:4] | flagSet;
      end
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[i] <= resetVal(i);
      else regs[i] <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intFlag <= 1'b0;
      intClrPulse <= 1'b0;
      calCnt <= '0;
    end else begin
      if (flagSet != 3'b000) intFlag <= 1'b1;
      else if (st.clrStatus || st.clrInt) intFlag <= 1'b0;
      intClrPulse <= st.clrStatus || st.clrInt;
      if (st.calLoad) calCnt <= CAL_W'(CAL_LOAD);
      else if (st.calDec) calCnt <= calCnt - 1'b1;
    end
  end

  // R4: register 12 keeps every bit but bit 6 across a write
  p_mode_bit_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrReg && st.wrSel == REG_MODE) |=> ((regs[REG_MODE] & 8'hBF) == ($past(regs[REG_MODE]) & 8'hBF)));

  // R7: register 11 never changes
  p_ro_cal_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(regs[REG_CALSTAT]));

  // R8: a status write with no new event leaves the flag clear
  p_status_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrStatus && flagSet == 3'b000) |=> (!intFlag && regs[REG_FLAGS][6:4] == 3'b000 && intClrPulse));

  // R13: an event always leaves the interrupt flag set
  p_event_sets_r13: assert property (@(posedge clk) disable iff (!rstN)
    (flagSet != 3'b000) |=> intFlag);
endmodule

// File: rtl/codec_index_regs.sv
module codec_index_regs
  import codec_regs_pkg::*;
#(
  parameter int CAL_LOAD = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] addr,
  input  logic wrEn,
  input  logic [7:0] wrData,
  input  logic rdEn,
  output logic [7:0] rdData,
  input  logic [2:0] flagSet,
  output logic [7:0] fmtReg,
  output logic [7:0] ifCfgReg,
  output logic irqOut,
  output logic intClrPulse
);
  localparam int CAL_W = $clog2(CAL_LOAD + 1);

  strobe_t st;
  logic [6:0] idxReg;
  logic [NREG-1:0][DW-1:0] regs;
  logic intFlag;
  logic [CAL_W-1:0] calCnt;

  codec_regs_ctrl #(.CAL_W(CAL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .idxReg(idxReg), .regs(regs), .intFlag(intFlag), .calCnt(calCnt),
    .st(st), .rdData(rdData)
  );

  codec_regs_dp #(.CAL_LOAD(CAL_LOAD), .CAL_W(CAL_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .flagSet(flagSet),
    .idxReg(idxReg), .regs(regs), .intFlag(intFlag), .calCnt(calCnt),
    .intClrPulse(intClrPulse)
  );

  assign fmtReg = regs[REG_FORMAT];
  assign ifCfgReg = regs[REG_IFCFG];
  assign irqOut = intFlag;

  // R6: bit 5 of the interface configuration never becomes 1
  p_ifcfg_bit5_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> !ifCfgReg[5]);
endmodule

// File: tb/codec_index_regs_test.sv
module codec_index_regs_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 34;
  // {isWrite, port, data, expected read}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 8'h00, 8'h40},  // R1 index reset
    {1'b1, 2'd0, 8'h82, 8'h00},  // R2 bit 7 dropped
    {1'b0, 2'd0, 8'h00, 8'h02},  // R2
    {1'b0, 2'd1, 8'h00, 8'h88},  // R1 reg 2
    {1'b1, 2'd1, 8'h5A, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h5A},  // R12 plain write/read
    {1'b1, 2'd0, 8'h0C, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h8A},  // R1 reg 12
    {1'b1, 2'd1, 8'hFF, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'hCA},  // R4 only bit 6
    {1'b1, 2'd0, 8'h13, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h88},  // R3 wide index reaches reg 19
    {1'b1, 2'd0, 8'h19, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'hA0},  // R1 reg 25
    {1'b1, 2'd0, 8'h16, 8'h00},
    {1'b1, 2'd1, 8'h55, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h00},  // R10 reserved 22
    {1'b1, 2'd0, 8'h08, 8'h00},
    {1'b1, 2'd1, 8'h7E, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h00},  // R5 dropped with MCE clear
    {1'b1, 2'd0, 8'h48, 8'h00},
    {1'b1, 2'd1, 8'h7E, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h7E},  // R5 full write with MCE
    {1'b1, 2'd0, 8'h09, 8'h00},
    {1'b1, 2'd1, 8'hFF, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'hDF},  // R6 bit 5 forced low
    {1'b1, 2'd0, 8'h4B, 8'h00},  // MCE rising edge loads counter
    {1'b0, 2'd1, 8'h00, 8'h20},  // R7 calibration bit once
    {1'b0, 2'd1, 8'h00, 8'h00},  // R7 then clear
    {1'b1, 2'd1, 8'hFF, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h00},  // R7 read-only
    {1'b1, 2'd3, 8'hAA, 8'h00},
    {1'b0, 2'd3, 8'h00, 8'h00},  // R11 PIO port
    {1'b0, 2'd0, 8'h00, 8'h4B}   // R12 index read unchanged
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] addr = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [7:0] rdData;
  logic [2:0] flagSet = '0;
  logic [7:0] fmtReg;
  logic [7:0] ifCfgReg;
  logic irqOut;
  logic intClrPulse;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  codec_index_regs uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .flagSet(flagSet), .fmtReg(fmtReg), .ifCfgReg(ifCfgReg),
    .irqOut(irqOut), .intClrPulse(intClrPulse)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseFlags(input logic [2:0] f);
    @(negedge clk);
    flagSet = f;
    @(negedge clk);
    flagSet = '0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset outputs
    check("R1 fmtReg", fmtReg, 8'h00);
    check("R1 ifCfgReg", ifCfgReg, 8'h08);
    check("R1 irqOut", {7'b0, irqOut}, 8'h00);
    check("R1 intClrPulse", {7'b0, intClrPulse}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][18]) wr(VEC[i][17:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][17:16], v);
        check($sformatf("vector %0d", i), v, VEC[i][7:0]);
      end
    end
    check("R5 fmtReg port", fmtReg, 8'h7E);
    check("R6 ifCfgReg port", ifCfgReg, 8'hDF);

    // R3 narrow index: 0x12 selects reg 2 with the wide mode bit clear
    wr(2'd0, 8'h0C); wr(2'd1, 8'h00);
    rd(2'd1, v); check("R4 mode bit cleared", v, 8'h8A);
    wr(2'd0, 8'h12);
    rd(2'd1, v); check("R3 narrow index", v, 8'h5A);

    // R13 playback event, R12 status reads are side-effect free
    wr(2'd0, 8'h0C); wr(2'd1, 8'h40);
    pulseFlags(3'b001);
    check("R13 irqOut", {7'b0, irqOut}, 8'h01);
    rd(2'd2, v); check("R12 status read 1", v, 8'h01);
    rd(2'd2, v); check("R12 status read 2", v, 8'h01);
    wr(2'd0, 8'h18);
    rd(2'd1, v); check("R13 flag reg", v, 8'h10);

    // R5 partial write: MCE clear, playback flag set
    wr(2'd0, 8'h08); wr(2'd1, 8'h35);
    check("R5 partial", fmtReg, 8'h3E);

    // R8 status write clears
    wr(2'd2, 8'h00);
    check("R8 pulse", {7'b0, intClrPulse}, 8'h01);
    check("R8 irqOut", {7'b0, irqOut}, 8'h00);
    @(negedge clk);
    check("R8 pulse width", {7'b0, intClrPulse}, 8'h00);
    wr(2'd0, 8'h18);
    rd(2'd1, v); check("R8 flag reg cleared", v, 8'h00);

    // R5 dropped again with flag clear
    wr(2'd0, 8'h08); wr(2'd1, 8'h91);
    check("R5 dropped", fmtReg, 8'h3E);

    // R9 flag-register write lowers playback bit
    pulseFlags(3'b001);
    wr(2'd0, 8'h18); wr(2'd1, 8'h00);
    check("R9 pulse", {7'b0, intClrPulse}, 8'h01);
    check("R9 irqOut", {7'b0, irqOut}, 8'h00);

    // R13 capture and timer events
    pulseFlags(3'b110);
    check("R13 irq multi", {7'b0, irqOut}, 8'h01);
    rd(2'd1, v); check("R13 flag bits", v, 8'h60);
    wr(2'd2, 8'hFF);
    rd(2'd1, v); check("R8 all flags cleared", v, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule